// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between a switching controller and the two gate drivers of a synchronous buck stage. The controller asks for the high-side switch, the low-side switch, or neither. The block turns those requests into two gate enables that never overlap. Dead time does not come from a fixed delay. Each turn-on waits for a sensed flag showing that the opposite switch has actually stopped conducting. A low side turn-on waits for the phase node to fall below its low threshold. A high side turn-on waits for the low gate voltage to fall below its threshold.

Every turn-on passes through a wait state with both gates off. If a flag never arrives, a cycle counter ends the wait after `TIMEOUT_CYCLES` cycles, lets the transition go ahead, and sets a sticky warning. A safe-state force drops the high side at once and then brings the low side up under the normal phase-low rule. The comparators and the analog drivers are outside this block and are seen only as the input flags.

Top module: `gate_deadtime_seq`

## Requirements
- R1: `ls_en` rises only from a wait state with both enables off. The rising edge needs `phase_low` sampled high at the clock edge that ends the wait, or else a timeout at that edge.
- R2: `hs_en` rises only from a wait state with both enables off. The rising edge needs `lgate_low` sampled high at the clock edge that ends the wait, or else a timeout at that edge.
- R3: `hs_en` and `ls_en` are never both high.
- R4: While `rst_n` is low, and in the first cycle after it is released, `ls_en` is 1, `hs_en` is 0 and `flag_timeout` is 0.
- R5: While `force_safe` is high, it counts as a low-side request. If `hs_en` was high, it is 0 from the cycle after the edge that sampled `force_safe`. The low side then turns on only under the rule of R1.
- R6: A wait ends by timeout when its flag has been low for `TIMEOUT_CYCLES` consecutive edges. That is the `TIMEOUT_CYCLES`-th edge after the edge that entered the wait. The transition then proceeds and `flag_timeout` goes to 1 and stays at 1 until reset.
- R7: A request that changes during a wait does not cut the wait short. When the wait ends, the request current at that edge decides the outcome. The same switch turns on; the other switch starts its own wait with a fresh count; no request goes to both off.
- R8: Request decode: `hs_req` = 1 (without force) means high side; `hs_req` = 0 with `ls_req` = 1 means low side; both 0 means neither. Dropping a request while its switch is on turns that switch off at the next edge, with no wait.
- R9: From the both-off idle state, a request for either switch enters the wait for that switch. The gate never turns on directly from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req | input | 1 | Request for the high-side switch (has priority) |
| ls_req | input | 1 | Request for the low-side switch |
| phase_low | input | 1 | Phase node is below its low threshold |
| lgate_low | input | 1 | Low gate voltage is below its off threshold |
| force_safe | input | 1 | Force safe state: high side off, low side on |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| flag_timeout | output | 1 | Sticky: a wait ended on timeout |

## Verification
The hardest case to reach is a wait that ends at exactly the edge where the counter expires while the request has moved to the opposite switch. That edge must hand over to a fresh wait instead of turning a gate on. The stimulus holds both feedback flags low for whole phases, so every wait runs to its full length. Requests change rarely and at random points, so some changes fall inside a running wait. Separate phases with mostly-high flags and with frequent force pulses cover fast handovers and forced recovery from the high-side-on state.

// File: rtl/gate_deadtime_seq.sv
module gate_deadtime_seq #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_req,
  input  logic ls_req,
  input  logic phase_low,
  input  logic lgate_low,
  input  logic force_safe,
  output logic hs_en,
  output logic ls_en,
  output logic flag_timeout
);
  localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);

  typedef enum logic [2:0] {ST_LS_ON, ST_HS_ON, ST_IDLE, ST_WAIT_HS, ST_WAIT_LS} st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic want_hs, want_ls, waiting, wait_flag, expired, done;

  assign want_hs   = hs_req & ~force_safe;
  assign want_ls   = force_safe | (ls_req & ~hs_req);
  assign waiting   = (st == ST_WAIT_HS) || (st == ST_WAIT_LS);
  assign wait_flag = (st == ST_WAIT_HS) ? lgate_low : phase_low;
  assign expired   = waiting && !wait_flag && (cnt == CNT_LAST);
  assign done      = waiting && (wait_flag || cnt == CNT_LAST);

  always_comb begin
    nxt = st;
    case (st)
      ST_LS_ON:   if (want_hs) nxt = ST_WAIT_HS; else if (!want_ls) nxt = ST_IDLE;
      ST_HS_ON:   if (want_ls) nxt = ST_WAIT_LS; else if (!want_hs) nxt = ST_IDLE;
      ST_IDLE:    if (want_hs) nxt = ST_WAIT_HS; else if (want_ls) nxt = ST_WAIT_LS;
      ST_WAIT_HS: if (done) nxt = want_hs ? ST_HS_ON : (want_ls ? ST_WAIT_LS : ST_IDLE);
      ST_WAIT_LS: if (done) nxt = want_ls ? ST_LS_ON : (want_hs ? ST_WAIT_HS : ST_IDLE);
      default:    nxt = ST_LS_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_LS_ON;
      cnt <= '0;
      flag_timeout <= 1'b0;
    end else begin
      st <= nxt;
      cnt <= (waiting && nxt == st) ? cnt + 1'b1 : '0;
      if (expired) flag_timeout <= 1'b1;
    end
  end

  assign hs_en = (st == ST_HS_ON);
  assign ls_en = (st == ST_LS_ON);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  assert_ls_after_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(!hs_en) && ($past(phase_low) || flag_timeout));

  assert_hs_after_lgate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(!ls_en) && ($past(lgate_low) || flag_timeout));

  assert_force_drops_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_safe |=> !hs_en);

  assert_warn_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_timeout |=> flag_timeout);

  assert_idle_no_direct_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en && !ls_en && !waiting) |=> !hs_en && !ls_en);
endmodule

// File: tb/gate_deadtime_seq_tb.sv
module gate_deadtime_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 4;

  logic clk = 0, rst_n = 0;
  logic hs_req = 0, ls_req = 0, phase_low = 0, lgate_low = 0, force_safe = 0;
  logic hs_en, ls_en, flag_timeout;
  int checks = 0, fails = 0;

  gate_deadtime_seq #(.TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
    .phase_low(phase_low), .lgate_low(lgate_low), .force_safe(force_safe),
    .hs_en(hs_en), .ls_en(ls_en), .flag_timeout(flag_timeout));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: 0 low on, 1 high on, 2 idle, 3 waiting for high, 4 waiting for low
  int m_mode = 0, m_cnt = 0;
  bit m_warn = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_warn = 0;
    end else begin
      bit goal_h, goal_l, fl, fin;
      int nm;
      goal_h = hs_req && !force_safe;
      goal_l = force_safe || (ls_req && !hs_req);
      nm = m_mode;
      fl = (m_mode == 3) ? lgate_low : phase_low;
      fin = fl || (m_cnt == TMO - 1);
      if (m_mode == 0) nm = goal_h ? 3 : (goal_l ? 0 : 2);
      else if (m_mode == 1) nm = goal_l ? 4 : (goal_h ? 1 : 2);
      else if (m_mode == 2) nm = goal_h ? 3 : (goal_l ? 4 : 2);
      else if (fin) begin
        if (m_mode == 3) nm = goal_h ? 1 : (goal_l ? 4 : 2);
        else nm = goal_l ? 0 : (goal_h ? 3 : 2);
        if (!fl) m_warn = 1;
      end
      m_cnt = (m_mode >= 3 && nm == m_mode) ? m_cnt + 1 : 0;
      m_mode = nm;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " hs_en (R2 R5 R7 R8)"}, hs_en, m_mode == 1);
    chk({tag, " ls_en (R1 R5 R7 R9)"}, ls_en, m_mode == 0);
    chk({tag, " flag_timeout (R6)"}, flag_timeout, m_warn);
    chk({tag, " overlap (R3)"}, hs_en & ls_en, 1'b0);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // kind: 0 random flags, 1 flags stuck low, 2 flags mostly high, 3 force bursts
  task automatic run_phase(input int kind, input int n, input string tag);
    rst_n = 0;
    @(negedge clk);
    chk({tag, " reset ls_en R4"}, ls_en, 1'b1);
    chk({tag, " reset hs_en R4"}, hs_en, 1'b0);
    chk({tag, " reset warn R4"}, flag_timeout, 1'b0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      check_all(tag);
      for (int k = 0; k < 3; k++) step_lfsr();
      if (lfsr[2:0] == 3'd0) begin hs_req = lfsr[3]; ls_req = lfsr[4]; end
      case (kind)
        0: begin phase_low = lfsr[5]; lgate_low = lfsr[6]; force_safe = 0; end
        1: begin phase_low = 0; lgate_low = 0; force_safe = 0; end
        2: begin phase_low = |lfsr[7:5]; lgate_low = |lfsr[10:8]; force_safe = 0; end
        default: begin phase_low = lfsr[5]; lgate_low = lfsr[6];
                       force_safe = (lfsr[11:9] == 3'd0); end
      endcase
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog R3: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Directed timeout: high request with lgate_low stuck low (R2 R6)
    chk("reset ls_en R4", ls_en, 1'b1);
    rst_n = 1; hs_req = 1;
    @(negedge clk);
    chk("wait entered R2", ls_en | hs_en, 1'b0);
    repeat (TMO - 1) @(negedge clk);
    chk("still waiting R6", hs_en, 1'b0);
    @(negedge clk);
    chk("timeout turn-on R6", hs_en, 1'b1);
    chk("timeout warn R6", flag_timeout, 1'b1);
    hs_req = 0; ls_req = 0;
    run_phase(0, 1500, "random");
    run_phase(1, 1500, "stuck");
    run_phase(2, 1500, "fast");
    run_phase(3, 1500, "force");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule